// File: doc/BRIEF.md
# Timestamp-Ordered Column-Sparsified Pixel Readout

This block reads out a matrix of hit pixels in timestamp order. A free-running timestamp counter advances once every fixed number of clock cycles and is broadcast to every pixel. When a pixel fires, it stores the counter value of that cycle and holds it until it is read or until the value ages out. The pixel array is modelled behaviourally as a set of latches; the analog front end is not part of the block.

To read a timestamp, the readout engine presents a requested timestamp to the matrix. Each pixel compares its stored value with the request. The per-pixel results combine into one fast-OR per column. A priority encoder then visits only the columns whose fast-OR is set, lowest index first, at one column per clock. Each visit emits one word that carries the whole column's matching-row bitmap, so the number of hits in a column does not change the cycle count. An end-of-timestamp word closes every request.

Two request sources are available. In streaming mode, every timestamp is requested when the counter moves past it. In triggered mode, only timestamps picked by a trigger pulse are requested, at a distance set by a latency input. The stored pixel values then serve as the latency buffer.

Top module: `mxro_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, `word_valid_o` and `frame_end_o` are 0. The timestamp counter starts at 0.
- R2: The timestamp counter increments by one modulo 2^TSW every TS_CYC clock cycles. A pixel whose hit input is high in a cycle stores the counter value of that cycle.
- R3: A pixel that already holds an unread hit ignores further hits until it is cleared.
- R4: In streaming mode (`trig_mode_i`=0), a counter increment that finds the engine idle starts a request for the value the counter held just before the increment.
- R5: In triggered mode (`trig_mode_i`=1), a `trig_i` pulse that finds the engine idle starts a request for (counter − `latency_i`) modulo 2^TSW. Triggers that arrive while the engine is busy are ignored, and counter increments start no request.
- R6: While a request is active, each cycle the lowest-index column with a matching pixel produces one word, visible two cycles after the cycle that started the request for the first column and one cycle apart after that. In that word `word_valid_o`=1, `col_o` is the column index, bit r of `rows_o` is set exactly when row r of that column matches, and `ts_o` is the requested timestamp.
- R7: The cycle after the last column word, or two cycles after the start cycle when no column matches, a single word with `frame_end_o`=1 and `ts_o` equal to the request ends the request. Only then can the next request start.
- R8: Every pixel reported in a word is cleared in the same cycle that produces the word, and it can record a new hit from the next cycle on.
- R9: At each counter increment, every stored pixel whose value equals the counter's next value is cleared without being reported.
- R10: `word_valid_o` and `frame_end_o` are never high together, and a column word never has an empty `rows_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_hit_i | input | NCOL*NROW | Per-pixel hit pulses, bit c*NROW+r for column c, row r |
| trig_mode_i | input | 1 | 0 selects streaming mode, 1 selects triggered mode |
| trig_i | input | 1 | Trigger pulse, used in triggered mode |
| latency_i | input | TSW | Trigger latency in timestamp units |
| word_valid_o | output | 1 | A column word is present |
| frame_end_o | output | 1 | End-of-timestamp marker |
| ts_o | output | TSW | Timestamp of the current request |
| col_o | output | CW | Column index of the word |
| rows_o | output | NROW | Matching-row bitmap of the column |

## Verification
A stale or wrongly cleared pixel latch does not show up at once. It appears when its timestamp is next requested, as an extra or missing bit in `rows_o`, which is up to one full counter wrap later in streaming mode. An error in the request arithmetic or the counter phase shows in the first word after the request as a wrong `ts_o` or a wrong frame boundary. The reference model therefore tracks every pixel latch and the engine state, and compares the outputs in every cycle. This way a divergence is reported in the cycle it first becomes visible, and not only at the end of a frame.

// File: rtl/mxro_pkg.sv
package mxro_pkg;
  typedef enum logic {
    ENG_IDLE = 1'b0,
    ENG_SCAN = 1'b1
  } eng_state_t;
endpackage

// File: rtl/mxro_tsgen.sv
module mxro_tsgen #(
  parameter int TSW    = 4,
  parameter int TS_CYC = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [TSW-1:0] ts_o,
  output logic           tick_o
);
  localparam int DW = (TS_CYC > 1) ? $clog2(TS_CYC) : 1;

  logic [DW-1:0]  div_q, div_d;
  logic [TSW-1:0] ts_q, ts_d;
  logic           tick;

  assign tick = (div_q == DW'(TS_CYC - 1));

  always_comb begin
    div_d = div_q + 1'b1;
    ts_d  = ts_q;
    if (tick) begin
      div_d = '0;
      ts_d  = ts_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      ts_q  <= '0;
    end else begin
      div_q <= div_d;
      ts_q  <= ts_d;
    end
  end

  assign ts_o   = ts_q;
  assign tick_o = tick;
endmodule

// File: rtl/mxro_column.sv
module mxro_column #(
  parameter int NROW = 8,
  parameter int TSW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NROW-1:0] hit_i,
  input  logic [TSW-1:0]  ts_i,
  input  logic [TSW-1:0]  req_ts_i,
  input  logic            match_en_i,
  input  logic            rd_clr_i,
  input  logic            age_i,
  input  logic [TSW-1:0]  age_ts_i,
  output logic            fast_or_o,
  output logic [NROW-1:0] rows_o
);
  logic [NROW-1:0]          vld_q, vld_d;
  logic [NROW-1:0][TSW-1:0] lts_q, lts_d;
  logic [NROW-1:0]          match;

  always_comb begin
    vld_d = vld_q;
    lts_d = lts_q;
    for (int r = 0; r < NROW; r++) begin
      match[r] = match_en_i && vld_q[r] && (lts_q[r] == req_ts_i);
      if ((rd_clr_i && match[r]) || (age_i && vld_q[r] && (lts_q[r] == age_ts_i))) begin
        vld_d[r] = 1'b0;
      end else if (!vld_q[r] && hit_i[r]) begin
        vld_d[r] = 1'b1;
        lts_d[r] = ts_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      lts_q <= '0;
    end else begin
      vld_q <= vld_d;
      lts_q <= lts_d;
    end
  end

  assign fast_or_o = |match;
  assign rows_o    = match;
endmodule

// File: rtl/mxro_colenc.sv
module mxro_colenc #(
  parameter int NCOL = 8,
  localparam int CW  = (NCOL > 1) ? $clog2(NCOL) : 1
) (
  input  logic [NCOL-1:0] col_or_i,
  output logic [CW-1:0]   sel_o,
  output logic            any_o
);
  always_comb begin
    sel_o = '0;
    for (int c = NCOL - 1; c >= 0; c--) begin
      if (col_or_i[c]) sel_o = CW'(c);
    end
  end

  assign any_o = |col_or_i;
endmodule

// File: rtl/mxro_top.sv
module mxro_top #(
  parameter int NCOL   = 8,
  parameter int NROW   = 8,
  parameter int TSW    = 4,
  parameter int TS_CYC = 12,
  localparam int CW    = (NCOL > 1) ? $clog2(NCOL) : 1,
  localparam int NPIX  = NCOL * NROW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIX-1:0] pix_hit_i,
  input  logic            trig_mode_i,
  input  logic            trig_i,
  input  logic [TSW-1:0]  latency_i,
  output logic            word_valid_o,
  output logic            frame_end_o,
  output logic [TSW-1:0]  ts_o,
  output logic [CW-1:0]   col_o,
  output logic [NROW-1:0] rows_o
);
  import mxro_pkg::*;

  logic [TSW-1:0] ts_cnt;
  logic           tick;
  logic [TSW-1:0] age_ts;

  eng_state_t     state_q, state_d;
  logic [TSW-1:0] req_q, req_d;
  logic           scan;
  logic           start;

  logic [NCOL-1:0]            col_or;
  logic [NCOL-1:0][NROW-1:0]  col_rows;
  logic [CW-1:0]              sel;
  logic                       any;

  logic            ov_q, ov_d, oe_q, oe_d;
  logic [TSW-1:0]  ots_q, ots_d;
  logic [CW-1:0]   ocol_q, ocol_d;
  logic [NROW-1:0] orows_q, orows_d;

  mxro_tsgen #(.TSW(TSW), .TS_CYC(TS_CYC)) u_tsgen (
    .clk    (clk),
    .rst_n  (rst_n),
    .ts_o   (ts_cnt),
    .tick_o (tick)
  );

  assign age_ts = ts_cnt + 1'b1;
  assign scan   = (state_q == ENG_SCAN);

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    mxro_column #(.NROW(NROW), .TSW(TSW)) u_col (
      .clk        (clk),
      .rst_n      (rst_n),
      .hit_i      (pix_hit_i[c*NROW +: NROW]),
      .ts_i       (ts_cnt),
      .req_ts_i   (req_q),
      .match_en_i (scan),
      .rd_clr_i   (scan && any && (sel == CW'(c))),
      .age_i      (tick),
      .age_ts_i   (age_ts),
      .fast_or_o  (col_or[c]),
      .rows_o     (col_rows[c])
    );
  end

  mxro_colenc #(.NCOL(NCOL)) u_enc (
    .col_or_i (col_or),
    .sel_o    (sel),
    .any_o    (any)
  );

  assign start = trig_mode_i ? trig_i : tick;

  always_comb begin
    state_d = state_q;
    req_d   = req_q;
    ov_d    = 1'b0;
    oe_d    = 1'b0;
    ots_d   = ots_q;
    ocol_d  = ocol_q;
    orows_d = '0;
    case (state_q)
      ENG_IDLE: begin
        if (start) begin
          state_d = ENG_SCAN;
          req_d   = trig_mode_i ? (ts_cnt - latency_i) : ts_cnt;
        end
      end
      default: begin
        ots_d = req_q;
        if (any) begin
          ov_d    = 1'b1;
          ocol_d  = sel;
          orows_d = col_rows[sel];
        end else begin
          oe_d    = 1'b1;
          state_d = ENG_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      req_q   <= '0;
      ov_q    <= 1'b0;
      oe_q    <= 1'b0;
      ots_q   <= '0;
      ocol_q  <= '0;
      orows_q <= '0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
      ov_q    <= ov_d;
      oe_q    <= oe_d;
      ots_q   <= ots_d;
      ocol_q  <= ocol_d;
      orows_q <= orows_d;
    end
  end

  assign word_valid_o = ov_q;
  assign frame_end_o  = oe_q;
  assign ts_o         = ots_q;
  assign col_o        = ocol_q;
  assign rows_o       = orows_q;
endmodule

// File: rtl/mxro_checker.sv
module mxro_checker #(
  parameter int TSW  = 4,
  parameter int NROW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            word_valid_i,
  input logic            frame_end_i,
  input logic [TSW-1:0]  ts_out_i,
  input logic [NROW-1:0] rows_i,
  input logic [TSW-1:0]  ts_cnt_i,
  input logic            tick_i
);
  AST_NO_DUAL_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_valid_i && frame_end_i)); // R10

  AST_ROWS_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_i |-> (rows_i != '0)); // R6

  AST_TS_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid_i && $past(word_valid_i)) |-> $stable(ts_out_i)); // R6

  AST_END_MATCHES_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end_i && $past(word_valid_i)) |-> $stable(ts_out_i)); // R7

  AST_END_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_i |=> !frame_end_i && !word_valid_i); // R7

  AST_TS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (ts_cnt_i == TSW'($past(ts_cnt_i) + 1'b1))); // R2

  AST_TS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(ts_cnt_i)); // R2
endmodule

bind mxro_top mxro_checker #(.TSW(TSW), .NROW(NROW)) u_mxro_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .word_valid_i (word_valid_o),
  .frame_end_i  (frame_end_o),
  .ts_out_i     (ts_o),
  .rows_i       (rows_o),
  .ts_cnt_i     (ts_cnt),
  .tick_i       (tick)
);

// File: tb/mxro_top_bench.sv
module mxro_top_bench;
  localparam int NCOL   = 8;
  localparam int NROW   = 8;
  localparam int TSW    = 4;
  localparam int TS_CYC = 12;
  localparam int CW     = 3;
  localparam int NPIX   = NCOL * NROW;

  logic            clk;
  logic            rst_n;
  logic [NPIX-1:0] pix_hit;
  logic            trig_mode;
  logic            trig;
  logic [TSW-1:0]  latency;
  logic            word_valid, frame_end;
  logic [TSW-1:0]  ts_out;
  logic [CW-1:0]   col_out;
  logic [NROW-1:0] rows_out;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  string cur_req = "R1";

  mxro_top #(.NCOL(NCOL), .NROW(NROW), .TSW(TSW), .TS_CYC(TS_CYC)) u_mxro_top (
    .clk          (clk),
    .rst_n        (rst_n),
    .pix_hit_i    (pix_hit),
    .trig_mode_i  (trig_mode),
    .trig_i       (trig),
    .latency_i    (latency),
    .word_valid_o (word_valid),
    .frame_end_o  (frame_end),
    .ts_o         (ts_out),
    .col_o        (col_out),
    .rows_o       (rows_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Reference model: pixel latches as arrays, engine as two flags
  bit             m_v [NPIX];
  bit [TSW-1:0]   m_t [NPIX];
  int             m_div;
  bit [TSW-1:0]   m_ts;
  bit             m_busy;
  bit [TSW-1:0]   m_rq;
  bit             e_v, e_e;
  bit [TSW-1:0]   e_ts;
  int             e_col;
  bit [NROW-1:0]  e_rows;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_v[p]) begin m_v[p] = 0; m_t[p] = '0; end
      m_div = 0; m_ts = '0; m_busy = 0; m_rq = '0;
      e_v = 0; e_e = 0; e_ts = '0; e_col = 0; e_rows = '0;
    end else begin
      bit tk, busy_old, st;
      int sel;
      bit clr [NPIX];
      tk = (m_div == TS_CYC - 1);
      busy_old = m_busy;
      sel = -1;
      foreach (clr[p]) clr[p] = 0;
      if (busy_old) begin
        for (int c = NCOL - 1; c >= 0; c--)
          for (int r = 0; r < NROW; r++)
            if (m_v[c*NROW+r] && m_t[c*NROW+r] == m_rq) sel = c;
      end
      e_v = 0; e_e = 0; e_rows = '0;
      if (busy_old) begin
        e_ts = m_rq;
        if (sel >= 0) begin
          e_v = 1; e_col = sel;
          for (int r = 0; r < NROW; r++)
            if (m_v[sel*NROW+r] && m_t[sel*NROW+r] == m_rq) begin
              e_rows[r] = 1'b1; clr[sel*NROW+r] = 1;
            end
        end else begin
          e_e = 1; m_busy = 0;
        end
      end
      for (int p = 0; p < NPIX; p++) begin
        if (clr[p] || (tk && m_v[p] && m_t[p] == TSW'(m_ts + 1))) m_v[p] = 0;
        else if (!m_v[p] && pix_hit[p]) begin m_v[p] = 1; m_t[p] = m_ts; end
      end
      st = trig_mode ? trig : tk;
      if (!busy_old && st) begin
        m_busy = 1;
        m_rq = trig_mode ? TSW'(m_ts - latency) : m_ts;
      end
      if (tk) begin m_div = 0; m_ts = m_ts + 1'b1; end
      else m_div = m_div + 1;
    end
  end

  task automatic compare_now();
    bit bad;
    compared++;
    bad = (word_valid !== e_v) || (frame_end !== e_e);
    if (!bad && (e_v || e_e) && ts_out !== e_ts) bad = 1;
    if (!bad && e_v && (col_out !== CW'(e_col) || rows_out !== e_rows)) bad = 1;
    if (bad) begin
      mismatched++;
      $display("FAIL %s R6/R7 cycle %0d: got v=%b e=%b ts=%0d col=%0d rows=%b, expected v=%b e=%b ts=%0d col=%0d rows=%b",
               cur_req, cycles, word_valid, frame_end, ts_out, col_out, rows_out,
               e_v, e_e, e_ts, e_col, e_rows);
    end
  endtask

  task automatic run(int n, int density_pct, int trig_period);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cycles++;
      compare_now();
      pix_hit = '0;
      for (int p = 0; p < NPIX; p++)
        if (int'($urandom_range(99)) < density_pct) pix_hit[p] = 1'b1;
      trig = (trig_period > 0) && ((i % trig_period) == 0);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #1000000;
    mismatched++;
    $display("FAIL watchdog expired, actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; pix_hit = '0; trig_mode = 1'b0; trig = 1'b0; latency = '0;
    repeat (3) @(negedge clk);
    // R1: outputs idle during reset
    compared++;
    if (word_valid !== 1'b0 || frame_end !== 1'b0) begin
      mismatched++;
      $display("FAIL R1 reset outputs: got v=%b e=%b expected v=0 e=0", word_valid, frame_end);
    end
    rst_n = 1'b1;
    // R1 and R7: streaming with no hits gives only frame-end words
    cur_req = "R7"; run(40, 0, 0);
    // R4, R6, R8: streaming with sparse hits
    cur_req = "R4"; run(600, 2, 0);
    // R6: dense hits, many columns per timestamp
    cur_req = "R6"; run(200, 25, 0);
    // R3: hits repeated on the same pixels keep the first stored value
    cur_req = "R3";
    for (int k = 0; k < 60; k++) begin
      @(negedge clk); cycles++; compare_now();
      pix_hit = {NCOL{8'b1000_0001}}; trig = 1'b0;
    end
    // R8: a single pixel fired every cycle re-arms after each read
    cur_req = "R8";
    for (int k = 0; k < 120; k++) begin
      @(negedge clk); cycles++; compare_now();
      pix_hit = '0; pix_hit[19] = 1'b1; trig = 1'b0;
    end
    // R5: triggered mode, latency 3, sparse triggers; R9 ages the rest
    cur_req = "R5"; trig_mode = 1'b1; latency = 4'd3; run(800, 3, 23);
    // R5: triggers back to back, most land while busy
    cur_req = "R5"; latency = 4'd1; run(300, 4, 2);
    // R9: long stretch without triggers, then triggers at the maximum latency
    cur_req = "R9"; run(400, 3, 0);
    latency = 4'd15; run(300, 3, 17);
    // R2: latency 0 requests the timestamp that is still counting
    cur_req = "R2"; latency = 4'd0; run(300, 5, 7);
    // R4: back to streaming
    cur_req = "R4"; trig_mode = 1'b0; run(300, 3, 0);
    finish_run();
  end
endmodule